// File: doc/BRIEF.md
# Register Ready Table with Operand Wakeup

This block keeps one ready flag for every physical register of an out-of-order core. Its register space is the integer bank plus the floating-point bank. It also holds a small set of issue slots that wait for their source operands. When an instruction is dispatched, the block reports which of its two sources can be used at once. The block also lowers the ready flag of the register the instruction will write.

A completing producer presents its destination tag. That tag raises the register's ready flag and is broadcast to every slot. A slot whose pending source matches the tag stops waiting on it. A slot can issue once none of its sources is pending. The slot-clear input drops a slot after a squash or an issue, so later broadcasts cannot bring that slot back to life.

Each slot is a small state machine with three states:
- `SLOT_FREE`: the slot is empty.
- `SLOT_WAIT`: one or more sources are still pending.
- `SLOT_READY`: the slot may issue.

The transitions are:
- *fill-ready*: FREE, WAIT or READY to READY, on a load whose two sources are ready.
- *fill-wait*: to WAIT, on a load with any pending source.
- *wake*: WAIT to READY, when the last pending source is broadcast.
- *drop*: to FREE, on a clear without a load.

Top module: `reg_wakeup_scoreboard`

## Requirements
- R1: After reset every register ready flag reads not-ready and every bit of `entry_ready` is 0.
- R2: For a tag below INT_REGS+FP_REGS, bit k of `disp_src_ready` is the OR of three terms. The first is the upstream flag for source k. The second is the register's ready flag. The third is a same-cycle completion carrying that same tag. The output is combinational and does not depend on `disp_valid`.
- R3: A tag at or above INT_REGS+FP_REGS is ignored for tracking. As a source it is always reported ready and never waited on. As a completion or a dispatch destination it changes no ready flag, even when its low bits equal a tracked register's index.
- R4: A dispatch with a tracked destination clears that register's flag from the next cycle. If a completion names the same register in the same cycle, the clear wins.
- R5: A completion with a tracked tag sets that register's flag from the next cycle.
- R6: A dispatch loads slot `disp_slot`. In the next cycle, that slot's `entry_ready` bit is 1 exactly when both sources were reported ready.
- R7: A tracked completion clears the matching pending source in every waiting slot. A slot's `entry_ready` bit rises in the cycle after the completion of its last pending source, and stays up until that slot is cleared or reloaded.
- R8: A bit of `slot_clear` frees that slot from the next cycle, and later broadcasts do not set it ready again. A dispatch into the same slot in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch an instruction this cycle |
| disp_slot | input | SLOT_W | Slot to load |
| disp_src0_tag | input | TAG_W | First source register tag |
| disp_src0_rdy | input | 1 | Upstream says first source is ready |
| disp_src1_tag | input | TAG_W | Second source register tag |
| disp_src1_rdy | input | 1 | Upstream says second source is ready |
| disp_dst_tag | input | TAG_W | Destination register tag |
| disp_src_ready | output | 2 | Per-source readiness seen at dispatch |
| cmpl_valid | input | 1 | A producer completes this cycle |
| cmpl_tag | input | TAG_W | Destination tag of the completing producer |
| slot_clear | input | ENTRIES | Per-slot release (squash or issue) |
| entry_ready | output | ENTRIES | Per-slot all-sources-ready flag |

## Verification
The bench uses INT_REGS=8, FP_REGS=8 and ENTRIES=4. This gives 16 tracked registers and a 5-bit tag. Tags 16 to 31 are therefore legal inputs, and their low four bits alias tracked indices, which puts the out-of-range filtering to a real test. With four slots, a single broadcast can wake several waiting slots at once. Random traffic also often lines up a completion with a dispatch on the same tag or the same slot.

// File: rtl/rws_pkg.sv
package rws_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;

    localparam int unsigned SRC_PER_SLOT = 2;
endpackage

// File: rtl/rws_ready_table.sv
module rws_ready_table #(
    parameter int NUM_REGS = 16,
    parameter int TAG_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_v,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_v,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic [TAG_W-1:0] q_tag0,
    input  logic [TAG_W-1:0] q_tag1,
    output logic             q_rdy0,
    output logic             q_rdy1
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0] rdy_q;
    logic set_hit, clr_hit;

    function automatic logic tracked(input logic [TAG_W-1:0] t);
        return 32'(t) < NUM_REGS;
    endfunction

    assign set_hit = set_v && tracked(set_tag);
    assign clr_hit = clr_v && tracked(clr_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= '0;
        end else begin
            if (set_hit) rdy_q[set_tag[IDX_W-1:0]] <= 1'b1;
            if (clr_hit) rdy_q[clr_tag[IDX_W-1:0]] <= 1'b0;
        end
    end

    always_comb begin
        q_rdy0 = tracked(q_tag0) &&
                 (rdy_q[q_tag0[IDX_W-1:0]] || (set_hit && set_tag == q_tag0));
        q_rdy1 = tracked(q_tag1) &&
                 (rdy_q[q_tag1[IDX_W-1:0]] || (set_hit && set_tag == q_tag1));
    end

    // R5
    set_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit && !(clr_hit && clr_tag == set_tag) |=> rdy_q[$past(set_tag[IDX_W-1:0])]);
    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> !rdy_q[$past(clr_tag[IDX_W-1:0])]);
endmodule

// File: rtl/rws_slot.sv
module rws_slot
    import rws_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clr,
    input  logic [TAG_W-1:0] tag0,
    input  logic [TAG_W-1:0] tag1,
    input  logic             rdy0,
    input  logic             rdy1,
    input  logic             bc_v,
    input  logic [TAG_W-1:0] bc_tag,
    output logic             entry_rdy
);
    slot_state_e state_q, state_nx;
    logic [TAG_W-1:0] tag_q [SRC_PER_SLOT];
    logic [SRC_PER_SLOT-1:0] wait_q, wait_nx, hit;

    always_comb begin
        for (int s = 0; s < SRC_PER_SLOT; s++)
            hit[s] = bc_v && wait_q[s] && (tag_q[s] == bc_tag);
        wait_nx  = wait_q & ~hit;
        state_nx = state_q;
        if (load) begin
            state_nx = (rdy0 && rdy1) ? SLOT_READY : SLOT_WAIT;
        end else if (clr) begin
            state_nx = SLOT_FREE;
        end else begin
            unique case (state_q)
                SLOT_FREE:  state_nx = SLOT_FREE;
                SLOT_WAIT:  if (wait_nx == '0) state_nx = SLOT_READY;
                SLOT_READY: state_nx = SLOT_READY;
                default:    state_nx = SLOT_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            for (int s = 0; s < SRC_PER_SLOT; s++) tag_q[s] <= '0;
        end else if (load) begin
            tag_q[0] <= tag0;
            tag_q[1] <= tag1;
            wait_q   <= {~rdy1, ~rdy0};
        end else if (clr) begin
            wait_q <= '0;
        end else if (state_q == SLOT_WAIT) begin
            wait_q <= wait_nx;
        end
    end

    always_comb entry_rdy = (state_q == SLOT_READY);

    // R8
    clr_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !load |=> state_q == SLOT_FREE);
    // R6
    load_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load && rdy0 && rdy1 |=> entry_rdy);
    // R7
    wait_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SLOT_WAIT |-> wait_q != '0);
    // R7
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SLOT_READY && !clr && !load |=> state_q == SLOT_READY);
endmodule

// File: rtl/reg_wakeup_scoreboard.sv
module reg_wakeup_scoreboard #(
    parameter int INT_REGS = 8,
    parameter int FP_REGS  = 8,
    parameter int ENTRIES  = 4,
    parameter int TAG_W    = $clog2(INT_REGS + FP_REGS) + 1,
    parameter int SLOT_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               disp_valid,
    input  logic [SLOT_W-1:0]  disp_slot,
    input  logic [TAG_W-1:0]   disp_src0_tag,
    input  logic               disp_src0_rdy,
    input  logic [TAG_W-1:0]   disp_src1_tag,
    input  logic               disp_src1_rdy,
    input  logic [TAG_W-1:0]   disp_dst_tag,
    output logic [1:0]         disp_src_ready,
    input  logic               cmpl_valid,
    input  logic [TAG_W-1:0]   cmpl_tag,
    input  logic [ENTRIES-1:0] slot_clear,
    output logic [ENTRIES-1:0] entry_ready
);
    localparam int NUM_REGS = INT_REGS + FP_REGS;

    logic tbl_rdy0, tbl_rdy1;
    logic trk0, trk1, bc_v;

    assign trk0 = 32'(disp_src0_tag) < NUM_REGS;
    assign trk1 = 32'(disp_src1_tag) < NUM_REGS;
    assign bc_v = cmpl_valid && (32'(cmpl_tag) < NUM_REGS);

    rws_ready_table #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) i_table (
        .clk(clk), .rst_n(rst_n),
        .set_v(cmpl_valid), .set_tag(cmpl_tag),
        .clr_v(disp_valid), .clr_tag(disp_dst_tag),
        .q_tag0(disp_src0_tag), .q_tag1(disp_src1_tag),
        .q_rdy0(tbl_rdy0), .q_rdy1(tbl_rdy1)
    );

    always_comb begin
        disp_src_ready[0] = !trk0 || disp_src0_rdy || tbl_rdy0;
        disp_src_ready[1] = !trk1 || disp_src1_rdy || tbl_rdy1;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        rws_slot #(.TAG_W(TAG_W)) i_slot (
            .clk(clk), .rst_n(rst_n),
            .load(disp_valid && disp_slot == SLOT_W'(g)),
            .clr(slot_clear[g]),
            .tag0(disp_src0_tag), .tag1(disp_src1_tag),
            .rdy0(disp_src_ready[0]), .rdy1(disp_src_ready[1]),
            .bc_v(bc_v), .bc_tag(cmpl_tag),
            .entry_rdy(entry_ready[g])
        );
    end
endmodule

// File: tb/test_reg_wakeup_scoreboard.sv
module test_reg_wakeup_scoreboard;
    localparam int CLK_P = 10;
    localparam int NR = 16;
    localparam int NE = 4;

    logic clk = 0, rst_n = 0;
    logic disp_valid = 0;
    logic [1:0] disp_slot = 0;
    logic [4:0] disp_src0_tag = 0, disp_src1_tag = 0, disp_dst_tag = 0, cmpl_tag = 0;
    logic disp_src0_rdy = 0, disp_src1_rdy = 0, cmpl_valid = 0;
    logic [1:0] disp_src_ready;
    logic [NE-1:0] slot_clear = 0, entry_ready;

    int n_run = 0, n_fail = 0;
    bit sb_m [NR];
    int st_m [NE];
    logic [4:0] tg_m [NE][2];
    bit wt_m [NE][2];

    always #(CLK_P/2) clk = ~clk;

    reg_wakeup_scoreboard i_reg_wakeup_scoreboard (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_slot(disp_slot),
        .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
        .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy),
        .disp_dst_tag(disp_dst_tag), .disp_src_ready(disp_src_ready),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
        .slot_clear(slot_clear), .entry_ready(entry_ready)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_src(logic [4:0] t, bit flag);
        if (t >= NR) return 1'b1;
        return flag || sb_m[t] || (cmpl_valid && cmpl_tag == t);
    endfunction

    function automatic logic [NE-1:0] exp_entries();
        logic [NE-1:0] v;
        for (int i = 0; i < NE; i++) v[i] = (st_m[i] == 2);
        return v;
    endfunction

    task automatic idle();
        disp_valid = 0; cmpl_valid = 0; slot_clear = 0;
        disp_src0_rdy = 0; disp_src1_rdy = 0;
    endtask

    // inputs set by caller after a negedge; checks src readiness, advances one edge, checks entries
    task automatic run_cycle(string req);
        bit e0, e1;
        #1;
        e0 = exp_src(disp_src0_tag, disp_src0_rdy);
        e1 = exp_src(disp_src1_tag, disp_src1_rdy);
        chk(req, 32'(disp_src_ready), 32'({e1, e0}));
        @(posedge clk);
        for (int i = 0; i < NE; i++) begin
            if (disp_valid && disp_slot == i) begin
                tg_m[i][0] = disp_src0_tag; tg_m[i][1] = disp_src1_tag;
                wt_m[i][0] = !e0; wt_m[i][1] = !e1;
                st_m[i] = (e0 && e1) ? 2 : 1;
            end else if (slot_clear[i]) begin
                st_m[i] = 0; wt_m[i][0] = 0; wt_m[i][1] = 0;
            end else if (st_m[i] == 1) begin
                for (int s = 0; s < 2; s++)
                    if (cmpl_valid && cmpl_tag < NR && wt_m[i][s] && tg_m[i][s] == cmpl_tag)
                        wt_m[i][s] = 0;
                if (!wt_m[i][0] && !wt_m[i][1]) st_m[i] = 2;
            end
        end
        if (cmpl_valid && cmpl_tag < NR) sb_m[cmpl_tag] = 1;
        if (disp_valid && disp_dst_tag < NR) sb_m[disp_dst_tag] = 0;
        @(negedge clk);
        chk(req, 32'(entry_ready), 32'(exp_entries()));
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NR; i++) sb_m[i] = 0;
        for (int i = 0; i < NE; i++) begin
            st_m[i] = 0; wt_m[i][0] = 0; wt_m[i][1] = 0; tg_m[i][0] = 0; tg_m[i][1] = 0;
        end
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1", 32'(entry_ready), 0);
        idle(); disp_src0_tag = 0; disp_src1_tag = 15;
        run_cycle("R1");

        // R2 R3 R6: completion bypass on src0, out-of-range src1
        idle(); disp_valid = 1; disp_slot = 0; disp_src0_tag = 5; disp_src1_tag = 17;
        disp_dst_tag = 20; cmpl_valid = 1; cmpl_tag = 5;
        run_cycle("R6");
        chk("R6", 32'(entry_ready[0]), 1);

        // R7: slot 1 waits on 6 and 7
        idle(); disp_valid = 1; disp_slot = 1; disp_src0_tag = 6; disp_src1_tag = 7; disp_dst_tag = 9;
        run_cycle("R7");
        idle(); cmpl_valid = 1; cmpl_tag = 6; run_cycle("R7");
        chk("R7", 32'(entry_ready[1]), 0);
        idle(); cmpl_valid = 1; cmpl_tag = 7; run_cycle("R7");
        chk("R7", 32'(entry_ready[1]), 1);

        // R8: dispatch beats clear on slot 1; clear of waiting slot 2 survives broadcast
        idle(); disp_valid = 1; disp_slot = 2; disp_src0_tag = 11; disp_src1_tag = 11; disp_dst_tag = 12;
        run_cycle("R8");
        idle(); slot_clear = 4'b0110; disp_valid = 1; disp_slot = 1;
        disp_src0_tag = 5; disp_src1_tag = 7; disp_dst_tag = 13; run_cycle("R8");
        chk("R8", 32'(entry_ready[2:1]), 32'(2'b01));
        idle(); cmpl_valid = 1; cmpl_tag = 11; run_cycle("R8");
        chk("R8", 32'(entry_ready[2]), 0);

        // R4: dispatch clear beats completion on register 9
        idle(); disp_valid = 1; disp_slot = 3; disp_src0_tag = 18; disp_src1_tag = 18;
        disp_dst_tag = 9; cmpl_valid = 1; cmpl_tag = 9; run_cycle("R4");
        idle(); disp_src0_tag = 9; disp_src1_tag = 9; run_cycle("R4");
        chk("R4", 32'(disp_src_ready), 0);

        // R3: out-of-range completion 19 aliases reg 3 low bits but must not set it
        idle(); cmpl_valid = 1; cmpl_tag = 19; disp_src0_tag = 3; run_cycle("R3");
        idle(); disp_src0_tag = 3; disp_src1_tag = 3; run_cycle("R3");
        chk("R3", 32'(disp_src_ready), 0);
        // R5: tracked completion sets the flag
        idle(); cmpl_valid = 1; cmpl_tag = 3; run_cycle("R5");
        idle(); disp_src0_tag = 3; disp_src1_tag = 3; run_cycle("R5");
        chk("R5", 32'(disp_src_ready), 3);

        // R2 R7: random traffic
        for (int c = 0; c < 3000; c++) begin
            idle();
            disp_valid    = ($urandom % 3) != 0;
            disp_slot     = 2'($urandom);
            disp_src0_tag = 5'($urandom % 20);
            disp_src1_tag = 5'($urandom % 20);
            disp_dst_tag  = 5'($urandom % 20);
            disp_src0_rdy = ($urandom % 4) == 0;
            disp_src1_rdy = ($urandom % 4) == 0;
            cmpl_valid    = ($urandom % 2) == 0;
            cmpl_tag      = 5'($urandom % 20);
            slot_clear    = (($urandom % 5) == 0) ? NE'($urandom) : '0;
            run_cycle((c % 2) == 0 ? "R2" : "R7");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule